// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This unit steers the operands and the flow of a six-stage in-order integer pipeline: fetch, decode, execute, memory-1, memory-2, writeback. Every cycle it compares the register numbers of the instruction in decode and the instruction in execute with the destinations of older instructions in flight. From these comparisons it produces three kinds of control. The first is the operand-bypass selects for the two execute operand multiplexers. The second is a hold for fetch and decode, which also forces a bubble into execute. The third is the kill controls used when a branch resolves taken in execute.

Memory access is spread over two stages, so load data becomes available only once the load has left memory-2. A consumer placed right behind a load waits two cycles in decode. A consumer placed one instruction further back waits one cycle. ALU results can be bypassed from three pipeline latches, so they never cause a wait. The control outputs are combinational in the current stage contents. The clock and reset feed only a small monitor register that bounds how long a hold can last.

Top module: `hazard_ctrl`

## Requirements
- R1: Each execute operand select is encoded as follows: 0 = register file, 1 = execute/memory-1 latch (producer now in memory-1), 2 = memory-1/memory-2 latch (producer now in memory-2), 3 = memory-2/writeback latch (producer now in writeback). A source is served by a stage whose instruction writes a nonzero destination equal to that source.
- R2: When no load in execute or memory-1 writes a register that decode reads, no hold is raised. ALU dependences never stall.
- R3: A consumer right behind a load is held in decode for exactly two cycles. It then enters execute with select 3 for that operand.
- R4: Load results are bypassed only from the memory-2/writeback latch. If the youngest matching producer is a load in memory-1 or memory-2, the select is 0.
- R5: fetch_hold, dec_hold and exe_bubble are always asserted together.
- R6: When several in-flight instructions write the same register, the youngest one (memory-1 before memory-2 before writeback) sets the select.
- R7: Register 0 never produces a nonzero select and never causes a hold.
- R8: A taken branch in execute raises fd_kill and de_kill and suppresses any hold in that cycle.
- R9: A source flagged unused, or a decode slot marked invalid, never causes a hold.
- R10: A consumer two slots behind a load is held for exactly one cycle.
- R11: With an empty pipeline every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold-length monitor |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decode slot holds a valid instruction |
| dec_src1 | input | REG_W | Decode first source register |
| dec_src2 | input | REG_W | Decode second source register |
| dec_use1 | input | 1 | Decode reads its first source |
| dec_use2 | input | 1 | Decode reads its second source |
| exe_src1 | input | REG_W | Execute first source register |
| exe_src2 | input | REG_W | Execute second source register |
| exe_dst | input | REG_W | Execute destination register |
| exe_wen | input | 1 | Execute instruction writes a register |
| exe_ld | input | 1 | Execute instruction is a load |
| exe_redirect | input | 1 | Branch in execute resolved taken |
| ma_dst | input | REG_W | Memory-1 destination register |
| ma_wen | input | 1 | Memory-1 instruction writes a register |
| ma_ld | input | 1 | Memory-1 instruction is a load |
| mb_dst | input | REG_W | Memory-2 destination register |
| mb_wen | input | 1 | Memory-2 instruction writes a register |
| mb_ld | input | 1 | Memory-2 instruction is a load |
| wb_dst | input | REG_W | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes a register |
| exe_byp1 | output | 2 | First execute operand select |
| exe_byp2 | output | 2 | Second execute operand select |
| fetch_hold | output | 1 | Hold the program counter and the fetch latch |
| dec_hold | output | 1 | Hold the decode latch |
| exe_bubble | output | 1 | Clear write and memory controls entering execute |
| fd_kill | output | 1 | Clear the valid bit of the fetch/decode latch |
| de_kill | output | 1 | Clear the valid bit of the decode/execute latch |

## Verification
The bench runs a behavioural pipeline that it fills with random loads, ALU operations, stores and branches drawn from a small register set, so that dependences are frequent. The first corner case is the load-use pair at distances one and two. A unit that also compared against memory-2 would add a third stall cycle. A unit that skipped memory-1 would send stale data after only one stall. The second corner case is a register written by several in-flight instructions. Here an oldest-first priority would select the wrong latch. Register 0 and unused sources are checked because a unit that missed either would raise false holds or false bypasses. Taken branches that arrive while a hold would otherwise apply are checked because a unit that let the hold win would keep a squashed instruction in decode.

// File: rtl/haz_pkg.sv
package haz_pkg;
  typedef enum logic [1:0] {
    BYP_RF = 2'd0,
    BYP_XM = 2'd1,
    BYP_MM = 2'd2,
    BYP_MW = 2'd3
  } byp_e;
endpackage

// File: rtl/byp_select.sv
module byp_select
  import haz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ma_dst,
  input  logic             ma_wen,
  input  logic             ma_ld,
  input  logic [REG_W-1:0] mb_dst,
  input  logic             mb_wen,
  input  logic             mb_ld,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output byp_e             sel
);
  logic src_nz, hit_ma, hit_mb, hit_wb;

  always_comb begin
    src_nz = (src != '0);
    hit_ma = src_nz && ma_wen && (ma_dst == src);
    hit_mb = src_nz && mb_wen && (mb_dst == src);
    hit_wb = src_nz && wb_wen && (wb_dst == src);
  end

  // youngest producer first; an unready load masks older copies
  always_comb begin
    if (hit_ma)      sel = ma_ld ? BYP_RF : BYP_XM;
    else if (hit_mb) sel = mb_ld ? BYP_RF : BYP_MM;
    else if (hit_wb) sel = BYP_MW;
    else             sel = BYP_RF;
  end
endmodule

// File: rtl/load_use_check.sv
module load_use_check #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             need,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             exe_wen,
  input  logic             exe_ld,
  input  logic [REG_W-1:0] ma_dst,
  input  logic             ma_wen,
  input  logic             ma_ld,
  output logic             hit
);
  logic live, exe_hit, ma_hit;

  always_comb begin
    live    = need && (src != '0);
    exe_hit = exe_ld && exe_wen && (exe_dst == src);
    ma_hit  = ma_ld && ma_wen && (ma_dst == src);
    hit     = live && (exe_hit || ma_hit);
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import haz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_OPS  = 2,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_vld,
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic             dec_use1,
  input  logic             dec_use2,
  input  logic [REG_W-1:0] exe_src1,
  input  logic [REG_W-1:0] exe_src2,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             exe_wen,
  input  logic             exe_ld,
  input  logic             exe_redirect,
  input  logic [REG_W-1:0] ma_dst,
  input  logic             ma_wen,
  input  logic             ma_ld,
  input  logic [REG_W-1:0] mb_dst,
  input  logic             mb_wen,
  input  logic             mb_ld,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       exe_byp1,
  output logic [1:0]       exe_byp2,
  output logic             fetch_hold,
  output logic             dec_hold,
  output logic             exe_bubble,
  output logic             fd_kill,
  output logic             de_kill
);
  localparam int RUN_W   = 2;
  localparam int RUN_MAX = (1 << RUN_W) - 1;

  logic [REG_W-1:0] id_src [NUM_OPS];
  logic             id_use [NUM_OPS];
  logic [REG_W-1:0] ex_src [NUM_OPS];
  logic [NUM_OPS-1:0] lu_hit;
  byp_e             sel [NUM_OPS];

  assign id_src[0] = dec_src1;
  assign id_src[1] = dec_src2;
  assign id_use[0] = dec_use1;
  assign id_use[1] = dec_use2;
  assign ex_src[0] = exe_src1;
  assign ex_src[1] = exe_src2;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    byp_select #(.REG_W(REG_W)) u_byp (
      .src(ex_src[g]), .ma_dst(ma_dst), .ma_wen(ma_wen), .ma_ld(ma_ld),
      .mb_dst(mb_dst), .mb_wen(mb_wen), .mb_ld(mb_ld),
      .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(sel[g])
    );
    load_use_check #(.REG_W(REG_W)) u_lu (
      .src(id_src[g]), .need(id_use[g]),
      .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_ld(exe_ld),
      .ma_dst(ma_dst), .ma_wen(ma_wen), .ma_ld(ma_ld),
      .hit(lu_hit[g])
    );
  end

  logic stall;
  always_comb begin
    stall      = dec_vld && (|lu_hit) && !exe_redirect;
    fetch_hold = stall;
    dec_hold   = stall;
    exe_bubble = stall;
    fd_kill    = exe_redirect;
    de_kill    = exe_redirect;
    exe_byp1   = sel[0];
    exe_byp2   = sel[1];
  end

  // hold-length monitor
  logic [RUN_W-1:0] hold_run, hold_run_nxt;
  always_comb begin
    if (!stall)                   hold_run_nxt = '0;
    else if (hold_run == RUN_MAX) hold_run_nxt = hold_run;
    else                          hold_run_nxt = hold_run + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_run <= '0;
    else        hold_run <= hold_run_nxt;
  end

  p_hold_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |-> (hold_run < 2'd2));
  p_hold_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |-> (fetch_hold && exe_bubble));
  p_redirect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exe_redirect |-> (fd_kill && de_kill && !dec_hold && !fetch_hold));
  p_ma_load_no_byp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_wen && ma_ld) |-> (exe_byp1 != 2'd1 && exe_byp2 != 2'd1));
  p_mb_load_no_byp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wen && mb_ld) |-> (exe_byp1 != 2'd2 && exe_byp2 != 2'd2));
  p_r0_no_byp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_src1 == '0) |-> (exe_byp1 == 2'd0));
  p_alu_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exe_ld && !ma_ld) |-> !dec_hold);
  p_idle_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !dec_hold);
endmodule

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
  typedef struct packed {
    logic       vld;
    logic [4:0] s1, s2;
    logic       u1, u2;
    logic [4:0] rd;
    logic       we, ld, br, tk;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic dec_vld, dec_use1, dec_use2, exe_wen, exe_ld, exe_redirect;
  logic ma_wen, ma_ld, mb_wen, mb_ld, wb_wen;
  logic [4:0] dec_src1, dec_src2, exe_src1, exe_src2, exe_dst, ma_dst, mb_dst, wb_dst;
  logic [1:0] exe_byp1, exe_byp2;
  logic fetch_hold, dec_hold, exe_bubble, fd_kill, de_kill;

  hazard_ctrl dut (.*);

  ins_t st [5];   // 0 decode, 1 execute, 2 mem-1, 3 mem-2, 4 writeback
  int checks = 0, errors = 0;
  int cov_dbl = 0, cov_one = 0, cov_ldfwd = 0, cov_multi = 0, cov_r0 = 0;
  int cov_redir = 0, cov_idle = 0;
  bit done = 0;

  function automatic ins_t gen();
    ins_t n = '0;
    int k = $urandom % 10;
    n.vld = 1'b1;
    n.s1 = 5'($urandom % 8); n.s2 = 5'($urandom % 8);
    n.rd = 5'($urandom % 8);
    if (k < 3)       begin n.u1 = 1; n.we = 1; n.ld = 1; end
    else if (k == 3) begin n.u1 = 1; n.u2 = 1; n.br = 1; n.tk = 1'($urandom % 2); end
    else if (k == 4) begin n.u1 = 1; n.u2 = 1; end
    else             begin n.u1 = 1; n.u2 = 1'($urandom % 2); n.we = 1; end
    return n;
  endfunction

  task automatic drive();
    dec_vld = st[0].vld; dec_src1 = st[0].s1; dec_src2 = st[0].s2;
    dec_use1 = st[0].u1; dec_use2 = st[0].u2;
    exe_src1 = st[1].s1; exe_src2 = st[1].s2; exe_dst = st[1].rd;
    exe_wen = st[1].we; exe_ld = st[1].ld;
    exe_redirect = st[1].vld && st[1].br && st[1].tk;
    ma_dst = st[2].rd; ma_wen = st[2].we; ma_ld = st[2].ld;
    mb_dst = st[3].rd; mb_wen = st[3].we; mb_ld = st[3].ld;
    wb_dst = st[4].rd; wb_wen = st[4].we;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected select: scan producers youngest first
  function automatic int exp_sel(input logic [4:0] src, output string tag);
    int code = 0, nmatch = 0;
    bit found = 0, unready = 0, ldwb = 0;
    for (int k = 2; k <= 4; k++) begin
      if (st[k].we && st[k].rd != 0 && st[k].rd == src) begin
        nmatch++;
        if (!found) begin
          found = 1;
          unready = st[k].ld && (k != 4);
          ldwb = st[k].ld && (k == 4);
          code = unready ? 0 : k - 1;
        end
      end
    end
    if (src == 0) tag = "R7";
    else if (unready) tag = "R4";
    else if (ldwb) begin tag = "R3"; cov_ldfwd++; end
    else if (nmatch > 1) begin tag = "R6"; cov_multi++; end
    else tag = "R1";
    return code;
  endfunction

  bit e_stall, e_redir;
  int run = 0;

  task automatic evaluate();
    string t1, t2, ht;
    int s1, s2;
    bit exl = 0, mal = 0;
    logic [4:0] src [2];
    logic use_ [2];
    src[0] = st[0].s1; src[1] = st[0].s2; use_[0] = st[0].u1; use_[1] = st[0].u2;
    e_redir = st[1].vld && st[1].br && st[1].tk;
    for (int j = 0; j < 2; j++) begin
      if (use_[j] && src[j] != 0) begin
        if (st[1].ld && st[1].rd == src[j]) exl = 1;
        if (st[2].ld && st[2].rd == src[j]) mal = 1;
      end
    end
    e_stall = st[0].vld && (exl || mal) && !e_redir;
    if (e_redir) begin ht = "R8"; cov_redir++; end
    else if (exl) ht = "R3";
    else if (mal) ht = "R10";
    else if (!st[0].vld || !(st[0].u1 && st[0].u2)) begin ht = "R9"; cov_idle++; end
    else ht = "R2";
    s1 = exp_sel(st[1].s1, t1);
    s2 = exp_sel(st[1].s2, t2);
    if (st[1].s1 == 0) cov_r0++;
    chk(t1, "exe_byp1", int'(exe_byp1), s1);
    chk(t2, "exe_byp2", int'(exe_byp2), s2);
    chk(ht, "dec_hold", int'(dec_hold), int'(e_stall));
    chk("R5", "fetch_hold", int'(fetch_hold), int'(e_stall));
    chk("R5", "exe_bubble", int'(exe_bubble), int'(e_stall));
    chk("R8", "fd_kill", int'(fd_kill), int'(e_redir));
    chk("R8", "de_kill", int'(de_kill), int'(e_redir));
    if (e_stall) begin
      run++;
      if (run == 2) cov_dbl++;
      if (run == 1 && !exl && mal) cov_one++;
    end else run = 0;
  endtask

  task automatic advance();
    st[4] = st[3]; st[3] = st[2]; st[2] = st[1];
    if (e_redir) begin st[1] = '0; st[0] = '0; end
    else if (e_stall) st[1] = '0;
    else begin st[1] = st[0]; st[0] = gen(); end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) st[i] = '0;
    drive();
    #23;
    // R11: empty pipeline gives all-zero outputs
    chk("R11", "exe_byp1", int'(exe_byp1), 0);
    chk("R11", "exe_byp2", int'(exe_byp2), 0);
    chk("R11", "dec_hold", int'(dec_hold), 0);
    chk("R11", "fd_kill", int'(fd_kill), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      advance();
      drive();
      #3;
      evaluate();
    end
    chk("R3", "double-hold occurrences seen", int'(cov_dbl > 0), 1);
    chk("R10", "single-hold occurrences seen", int'(cov_one > 0), 1);
    chk("R3", "load bypass from writeback latch seen", int'(cov_ldfwd > 0), 1);
    chk("R6", "multi-producer cases seen", int'(cov_multi > 0), 1);
    chk("R7", "register 0 sources seen", int'(cov_r0 > 0), 1);
    chk("R8", "taken branches seen", int'(cov_redir > 0), 1);
    chk("R9", "unused or invalid source cases seen", int'(cov_idle > 0), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule